// File: doc/BRIEF.md
# Adapter Board Control and Parity-Error Capture

This block gives a host a small register window onto an adapter board. A 16-bit control/status word holds the board's mode bits and drives them out as pins. The mode bits are board reset, on-air (out of loopback), interrupt enables, auxiliary bus enable, large memory part select and the high memory-address nibble. Writing the attention bit sends a single-cycle strobe to the attached network controller. The same word reports a registered copy of the controller's interrupt request and a pending parity-error flag.

A small two-state machine guards the parity-error capture. In `CAP_IDLE` the first parity event loads the 20-bit failing address, the requester bit and the byte-lane bit, and the machine moves to `CAP_HELD` (transition *capture*). In `CAP_HELD` every further event is dropped. A host write of 1 to the acknowledge bit returns the machine to `CAP_IDLE` (transition *release*). The captured values stay readable until the next capture replaces them. The board interrupt line combines the two flags with their enables.

Three host addresses are decoded: 0 is the control/status word, 1 is the parity control word (acknowledge, requester, lane and address bits 19..16), and 2 is address bits 15..0 of the captured failure. Address 3 reads as zero. Writes to 2 and 3 have no effect.

Top module: `board_ctl`

## Requirements
- R1: After reset all three registers read 0x0000, and the outputs board_rst, on_air, aux_bus_en, mem256k, mem_hi_addr, attn_pulse and irq are all 0.
- R2: At address 0, a write stores bit 15 (board_rst), bit 14 (on_air), bit 12 (interrupt enable), bit 11 (parity interrupt enable), bit 5 (aux_bus_en), bit 4 (mem256k) and bits [3:0] (mem_hi_addr). These bits read back and drive their output pins from the cycle after the write.
- R3: Writing 1 to bit 13 of address 0 raises attn_pulse for exactly the one cycle after the write. A write with bit 13 clear gives no pulse. Bit 13 always reads 0.
- R4: Bit 8 of address 0 reads ctl_irq_req as sampled at the previous clock edge. Bits 9 and 8 ignore host writes.
- R5: In CAP_IDLE, a parity event (par_evt high at a clock edge) moves the machine to CAP_HELD and latches the event data. Bit 9 of address 0 reads 1. Address 1 shows par_src in bit 7, par_lane in bit 6 and par_addr[19:16] in bits [3:0]. Address 2 shows par_addr[15:0].
- R6: In CAP_HELD, parity events leave addresses 1 and 2 unchanged.
- R7: Writing 1 to bit 8 of address 1 in CAP_HELD returns the machine to CAP_IDLE and clears bit 9. Captured values remain readable. A parity event in the same cycle as that acknowledge is dropped. Bit 8 of address 1 always reads 0.
- R8: irq equals (interrupt flag AND interrupt enable) OR (parity flag AND parity interrupt enable).
- R9: Address 3 reads 0x0000. Writes to addresses 2 and 3, and to bits of address 1 other than bit 8, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr (combinational) |
| ctl_irq_req | input | 1 | Interrupt request from the controller |
| par_evt | input | 1 | Parity error event, one per cycle high |
| par_addr | input | 20 | Failing memory address |
| par_src | input | 1 | Requester that saw the error |
| par_lane | input | 1 | Byte half that failed |
| board_rst | output | 1 | Holds the controller in reset while 1 |
| on_air | output | 1 | 1 = on air, 0 = loopback |
| attn_pulse | output | 1 | One-cycle attention strobe |
| aux_bus_en | output | 1 | Auxiliary memory bus enable |
| mem256k | output | 1 | Large memory part select |
| mem_hi_addr | output | 4 | Memory address bits 20..17 |
| irq | output | 1 | Board interrupt line |

## Verification
The two functions that can fall in the same cycle are the host acknowledge of a pending parity error and a fresh parity event. The bench drives both on the same clock edge while an error is pending. It then expects the flag to read clear and addresses 1 and 2 to keep the earlier capture, because the event met CAP_HELD. A later isolated event must be captured, which shows that the machine did reach CAP_IDLE.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int REG_W = 16;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_PCTL = 2'd1;
    localparam logic [1:0] A_PLOW = 2'd2;

    // control/status bit positions
    localparam int B_RST  = 15;
    localparam int B_AIR  = 14;
    localparam int B_ATN  = 13;
    localparam int B_IEN  = 12;
    localparam int B_PIEN = 11;
    localparam int B_PERR = 9;
    localparam int B_INT  = 8;
    localparam int B_AUX  = 5;
    localparam int B_M256 = 4;

    // parity control bit positions
    localparam int P_ACK  = 8;
    localparam int P_SRC  = 7;
    localparam int P_LANE = 6;

endpackage

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int HI_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stat,
    input  logic [REG_W-1:0]     wdata,
    output logic                 board_rst,
    output logic                 on_air,
    output logic                 ien,
    output logic                 pien,
    output logic                 aux_bus_en,
    output logic                 mem256k,
    output logic [HI_W-1:0]      mem_hi_addr,
    output logic                 attn_pulse
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[10:6], wdata[HI_W +: (4 - HI_W + 1)]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            board_rst   <= 1'b0;
            on_air      <= 1'b0;
            ien         <= 1'b0;
            pien        <= 1'b0;
            aux_bus_en  <= 1'b0;
            mem256k     <= 1'b0;
            mem_hi_addr <= '0;
            attn_pulse  <= 1'b0;
        end else begin
            attn_pulse <= wr_stat && wdata[B_ATN];
            if (wr_stat) begin
                board_rst   <= wdata[B_RST];
                on_air      <= wdata[B_AIR];
                ien         <= wdata[B_IEN];
                pien        <= wdata[B_PIEN];
                aux_bus_en  <= wdata[B_AUX];
                mem256k     <= wdata[B_M256];
                mem_hi_addr <= wdata[HI_W-1:0];
            end
        end
    end

endmodule

// File: rtl/board_ctl_capture.sv
module board_ctl_capture
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              par_evt,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic              par_src,
    input  logic              par_lane,
    output logic              err_flag,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_src,
    output logic              cap_lane
);

    cap_state_e state_q, state_d;
    logic       load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (par_evt) begin
                    state_d = CAP_HELD;   // capture
                    load    = 1'b1;
                end
            end
            CAP_HELD: begin
                if (ack) begin
                    state_d = CAP_IDLE;   // release; coincident event dropped
                end
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_src  <= 1'b0;
            cap_lane <= 1'b0;
        end else if (load) begin
            cap_addr <= par_addr;
            cap_src  <= par_src;
            cap_lane <= par_lane;
        end
    end

    // outputs
    always_comb begin
        err_flag = (state_q == CAP_HELD);
    end

endmodule

// File: rtl/board_ctl_irq.sv
module board_ctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_irq_req,
    input  logic ien,
    input  logic pien,
    input  logic err_flag,
    output logic int_flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) int_flag <= 1'b0;
        else        int_flag <= ctl_irq_req;
    end

    always_comb begin
        irq = (int_flag && ien) || (err_flag && pien);
    end

endmodule

// File: rtl/board_ctl.sv
module board_ctl
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              ctl_irq_req,
    input  logic              par_evt,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic              par_src,
    input  logic              par_lane,
    output logic              board_rst,
    output logic              on_air,
    output logic              attn_pulse,
    output logic              aux_bus_en,
    output logic              mem256k,
    output logic [ADDR_W-17:0] mem_hi_addr,
    output logic              irq
);

    localparam int HI_W = ADDR_W - 16;

    logic              wr_stat, ack;
    logic              ien, pien, int_flag, err_flag;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_src, cap_lane;
    logic [REG_W-1:0]  stat_word, pctl_word;

    assign wr_stat = reg_we && (reg_addr == A_STAT);
    assign ack     = reg_we && (reg_addr == A_PCTL) && reg_wdata[P_ACK];

    board_ctl_regs #(.HI_W(HI_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stat     (wr_stat),
        .wdata       (reg_wdata),
        .board_rst   (board_rst),
        .on_air      (on_air),
        .ien         (ien),
        .pien        (pien),
        .aux_bus_en  (aux_bus_en),
        .mem256k     (mem256k),
        .mem_hi_addr (mem_hi_addr),
        .attn_pulse  (attn_pulse)
    );

    board_ctl_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack      (ack),
        .par_evt  (par_evt),
        .par_addr (par_addr),
        .par_src  (par_src),
        .par_lane (par_lane),
        .err_flag (err_flag),
        .cap_addr (cap_addr),
        .cap_src  (cap_src),
        .cap_lane (cap_lane)
    );

    board_ctl_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_irq_req (ctl_irq_req),
        .ien         (ien),
        .pien        (pien),
        .err_flag    (err_flag),
        .int_flag    (int_flag),
        .irq         (irq)
    );

    // readback
    always_comb begin
        stat_word           = '0;
        stat_word[B_RST]    = board_rst;
        stat_word[B_AIR]    = on_air;
        stat_word[B_IEN]    = ien;
        stat_word[B_PIEN]   = pien;
        stat_word[B_PERR]   = err_flag;
        stat_word[B_INT]    = int_flag;
        stat_word[B_AUX]    = aux_bus_en;
        stat_word[B_M256]   = mem256k;
        stat_word[HI_W-1:0] = mem_hi_addr;

        pctl_word           = '0;
        pctl_word[P_SRC]    = cap_src;
        pctl_word[P_LANE]   = cap_lane;
        pctl_word[HI_W-1:0] = cap_addr[ADDR_W-1:16];

        unique case (reg_addr)
            A_STAT:  reg_rdata = stat_word;
            A_PCTL:  reg_rdata = pctl_word;
            A_PLOW:  reg_rdata = cap_addr[15:0];
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic              par_evt,
    input logic              attn_pulse,
    input logic              irq,
    input logic              ien,
    input logic              pien,
    input logic              err_flag,
    input logic [ADDR_W-1:0] cap_addr
);

    // R3
    attn_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |-> $past(reg_we && reg_addr == A_STAT && reg_wdata[B_ATN]));

    // R3
    attn_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STAT) |-> !reg_rdata[B_ATN]);

    // R5
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_evt && !err_flag) |=> err_flag);

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && $past(err_flag)) |-> $stable(cap_addr));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PCTL && reg_wdata[P_ACK] && err_flag) |=> !err_flag);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien && !pien) |-> !irq);

endmodule

bind board_ctl board_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .par_evt    (par_evt),
    .attn_pulse (attn_pulse),
    .irq        (irq),
    .ien        (ien),
    .pien       (pien),
    .err_flag   (err_flag),
    .cap_addr   (cap_addr)
);

// File: tb/board_ctl_tb.sv
module board_ctl_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ctl_irq_req = 1'b0;
    logic        par_evt = 1'b0;
    logic [19:0] par_addr = 20'h0;
    logic        par_src = 1'b0;
    logic        par_lane = 1'b0;
    logic        board_rst, on_air, attn_pulse, aux_bus_en, mem256k, irq;
    logic [3:0]  mem_hi_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int          sel;   // 0 rdata, 1 irq, 2 attn, 3 pins
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    board_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_irq_req(ctl_irq_req),
        .par_evt(par_evt), .par_addr(par_addr), .par_src(par_src), .par_lane(par_lane),
        .board_rst(board_rst), .on_air(on_air), .attn_pulse(attn_pulse),
        .aux_bus_en(aux_bus_en), .mem256k(mem256k), .mem_hi_addr(mem_hi_addr), .irq(irq)
    );

    // monitor: pops expected items and compares with observed outputs
    initial begin
        forever begin
            item_t it;
            logic [15:0] got;
            wait (q.size() > 0);
            #0.1;
            it = q.pop_front();
            case (it.sel)
                0:       got = reg_rdata;
                1:       got = {15'h0, irq};
                2:       got = {15'h0, attn_pulse};
                default: got = {8'h0, board_rst, on_air, aux_bus_en, mem256k, mem_hi_addr};
            endcase
            n_vec++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    // driver: push expected item and wait for the monitor
    task automatic obs(int sel, logic [1:0] a, logic [15:0] e, string tag);
        item_t it;
        reg_addr = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        #0.1;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 16'h0;
    endtask

    task automatic perr(logic [19:0] a, logic s, logic l);
        @(negedge clk);
        par_evt = 1'b1; par_addr = a; par_src = s; par_lane = l;
        @(negedge clk);
        par_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        obs(0, 2'd0, 16'h0000, "R1 status");
        obs(0, 2'd1, 16'h0000, "R1 pctl");
        obs(0, 2'd2, 16'h0000, "R1 plow");
        obs(3, 2'd0, 16'h0000, "R1 pins");
        obs(1, 2'd0, 16'h0000, "R1 irq");
        obs(2, 2'd0, 16'h0000, "R1 attn");

        // R2 / R4: mode bits, flags not writable
        wr(2'd0, 16'hDB3A);
        obs(0, 2'd0, 16'hD83A, "R2 R4 status readback");
        obs(3, 2'd0, 16'h00FA, "R2 pins");
        obs(2, 2'd0, 16'h0000, "R3 no pulse without bit13");

        // R3 attention pulse
        wr(2'd0, 16'h3005);
        obs(2, 2'd0, 16'h0001, "R3 pulse");
        obs(0, 2'd0, 16'h1005, "R3 bit13 reads 0");
        obs(3, 2'd0, 16'h0005, "R2 pins cleared");
        @(negedge clk);
        obs(2, 2'd0, 16'h0000, "R3 pulse one cycle");

        // R4 / R8 interrupt flag
        ctl_irq_req = 1'b1;
        @(negedge clk);
        obs(0, 2'd0, 16'h1105, "R4 int flag");
        obs(1, 2'd0, 16'h0001, "R8 irq via ien");
        wr(2'd0, 16'h0005);
        obs(1, 2'd0, 16'h0000, "R8 irq masked");
        ctl_irq_req = 1'b0;
        @(negedge clk);
        obs(0, 2'd0, 16'h0005, "R4 int flag clear");

        // R5 capture
        perr(20'hABCDE, 1'b1, 1'b0);
        obs(0, 2'd0, 16'h0205, "R5 perr flag");
        obs(0, 2'd1, 16'h008A, "R5 pctl");
        obs(0, 2'd2, 16'hBCDE, "R5 plow");
        obs(1, 2'd0, 16'h0000, "R8 pien off");
        wr(2'd0, 16'h0805);
        obs(1, 2'd0, 16'h0001, "R8 irq via pien");
        obs(0, 2'd0, 16'h0A05, "R5 flag with pien");

        // R6 hold
        perr(20'h12345, 1'b0, 1'b1);
        obs(0, 2'd1, 16'h008A, "R6 pctl held");
        obs(0, 2'd2, 16'hBCDE, "R6 plow held");

        // R7 acknowledge
        wr(2'd1, 16'h0100);
        obs(0, 2'd0, 16'h0805, "R7 flag cleared");
        obs(1, 2'd0, 16'h0000, "R7 irq cleared");
        obs(0, 2'd1, 16'h008A, "R7 ack reads 0, data kept");

        perr(20'h51234, 1'b0, 1'b1);
        obs(0, 2'd1, 16'h0045, "R7 rearmed pctl");
        obs(0, 2'd2, 16'h1234, "R7 rearmed plow");

        // R7 ack and event in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0100;
        par_evt = 1'b1; par_addr = 20'hFFFFF; par_src = 1'b1; par_lane = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 16'h0; par_evt = 1'b0;
        obs(0, 2'd0, 16'h0805, "R7 coincident flag");
        obs(0, 2'd1, 16'h0045, "R7 coincident pctl");
        obs(0, 2'd2, 16'h1234, "R7 coincident plow");

        // R9 address map
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        wr(2'd1, 16'h00FF);
        obs(0, 2'd2, 16'h1234, "R9 plow write ignored");
        obs(0, 2'd3, 16'h0000, "R9 addr3 zero");
        obs(0, 2'd1, 16'h0045, "R9 pctl write ignored");
        obs(0, 2'd0, 16'h0805, "R9 status untouched");

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule